// File: doc/BRIEF.md
# Two-Byte Instruction Fetch Sequencer

This block fetches one 16-bit instruction from a byte-wide memory, one byte at a time, through a general datapath slice. The program counter is held in register 7. For each byte the sequencer passes the counter through the ALU with an OR of the register with itself and loads the result into the memory address register. It then reads memory into the matching half of the instruction register, holding the read while the memory wait line is high. Finally it advances the counter through the ALU with a pass-with-carry operation and carry-in set. No dedicated incrementer exists. The counter only moves through the ALU.

A pulse on the start input begins a fetch. Each cycle the block drives a flat control word: operand selects, ALU operation, carry-in, result select, and the load, read and write strobes. The internal datapath slice executes that word. The address register drives the memory address. When both bytes are in the instruction register, the block raises a one-cycle done pulse and returns to idle. A parameter chooses between two control programs. The sequential program uses one control step per action and a separate wait test. The overlapped program merges the counter increment into the last cycle of each read. Both programs leave the same instruction word and the same counter value.

Top module: `fetch_seq`

## Requirements
- R1: While rst_ni is low, every control output and done_o are 0, pc_o equals the parameter PC_RST, and ir_o is 0.
- R2: While the block is idle, every control output and done_o stay 0, and pc_o and ir_o hold their values.
- R3: A byte is taken from memory in a cycle with rd_o high and mem_wait_i low. The first byte of a fetch is read at address P, the counter value at start. The second byte is read at P+1, modulo 2^W.
- R4: When done_o is high, ir_o holds the second byte in bits [2W-1:W] and the first byte in bits [W-1:0]. ir_lo_ld_o selects the low half and ir_hi_ld_o selects the high half.
- R5: Each completed fetch advances pc_o by exactly 2, modulo 2^W. Every cycle with pc_we_o high raises pc_o by 1 at the next edge.
- R6: done_o is high for exactly one cycle per fetch, and the block is idle in the cycle after it. A start_i pulse while a fetch is in progress has no effect.
- R7: Let cycle 0 be a cycle in which start_i is high while the block is idle. Let K be the number of read cycles per byte in which mem_wait_i is high. Then done_o is high in cycle 9+4K in the sequential program (OVERLAP=0) and in cycle 5+2K in the overlapped program (OVERLAP=1).
- R8: The control word uses this encoding. A cycle with mar_ld_o high drives a_sel_o=7, b_sel_o=7 and alu_sel_o=1 (OR). A cycle with pc_we_o high drives a_sel_o=7, cin_o=1, alu_sel_o=6 (pass A plus carry) and res_sel_o=0 (ALU). Exactly one of ir_lo_ld_o and ir_hi_ld_o is high when rd_o is high, and neither is high otherwise.
- R9: In the overlapped program, every read cycle with mem_wait_i low also has pc_we_o high. In the sequential program, pc_we_o is never high together with rd_o.
- R10: pc_we_o is never high together with mar_ld_o, and never high in a read cycle where mem_wait_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a fetch when idle |
| mem_wait_i | input | 1 | Memory not ready for the current read |
| mem_rdata_i | input | W | Memory read data |
| mem_addr_o | output | W | Memory address (address register) |
| a_sel_o | output | 3 | A operand register select |
| b_sel_o | output | 3 | B operand register select |
| alu_sel_o | output | 3 | ALU operation code |
| cin_o | output | 1 | ALU carry-in |
| res_sel_o | output | 2 | Result source select, 0 = ALU |
| mar_ld_o | output | 1 | Load address register from ALU |
| rd_o | output | 1 | Memory read strobe |
| ir_lo_ld_o | output | 1 | Load low instruction half from memory |
| ir_hi_ld_o | output | 1 | Load high instruction half from memory |
| pc_we_o | output | 1 | Write register 7 from the result bus |
| done_o | output | 1 | One-cycle fetch-complete pulse |
| pc_o | output | W | Register 7, the program counter |
| ir_o | output | 2W | Instruction register |

## Verification
In the overlapped program, the final read cycle of a byte and the counter increment fall in the same cycle. The read uses the old address already latched in the address register, and the ALU computes the new counter value. The bench provokes this with stall counts of zero and nonzero, so the shared cycle happens both immediately and after several wait cycles. It judges the result by the address seen at each byte read, the instruction word, and the counter after done. A sequential instance runs on the same stimulus, and it must reach the same word and counter, each program within its own cycle count.

// File: rtl/fetch_seq_pkg.sv
package fetch_seq_pkg;
  localparam int SEL_W = 3;
  localparam int RES_W = 2;

  typedef enum logic [2:0] {
    ALU_AND  = 3'd0,
    ALU_OR   = 3'd1,
    ALU_XOR  = 3'd2,
    ALU_NOT  = 3'd3,
    ALU_ADD  = 3'd4,
    ALU_SUB  = 3'd5,
    ALU_ADDA = 3'd6,
    ALU_SUBA = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] a_sel;
    logic [SEL_W-1:0] b_sel;
    alu_op_e          alu;
    logic             cin;
    logic [RES_W-1:0] res_sel;
    logic             mar_ld;
    logic             rd;
    logic             ir_lo_ld;
    logic             ir_hi_ld;
    logic             pc_we;
  } ctl_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MAR0, ST_RD0, ST_CHK0, ST_INC0,
    ST_MAR1, ST_RD1, ST_CHK1, ST_INC1, ST_DONE
  } st_e;
endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_seq_pkg::*;
#(
  parameter int               OVERLAP = 1,
  parameter logic [SEL_W-1:0] PC_REG  = 3'd7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_wait_i,
  output ctl_t ctl_o,
  output logic done_o
);
  st_e  st, nxt;
  logic stall_q;
  logic in_rd;

  assign in_rd = (st == ST_RD0) || (st == ST_RD1);

  // sequential program tests a latched copy of the wait seen in the read step
  if (OVERLAP == 0) begin : g_seq
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stall_q <= 1'b0;
      else if (in_rd) stall_q <= mem_wait_i;
    end
  end else begin : g_ovl
    assign stall_q = 1'b0;
  end

  function automatic ctl_t add_inc(input ctl_t c);
    ctl_t r;
    r         = c;
    r.a_sel   = PC_REG;
    r.alu     = ALU_ADDA;
    r.cin     = 1'b1;
    r.res_sel = '0;
    r.pc_we   = 1'b1;
    return r;
  endfunction

  always_comb begin
    nxt    = st;
    ctl_o  = '0;
    done_o = 1'b0;
    unique case (st)
      ST_IDLE: if (start_i) nxt = ST_MAR0;
      ST_MAR0, ST_MAR1: begin
        ctl_o.a_sel  = PC_REG;
        ctl_o.b_sel  = PC_REG;
        ctl_o.alu    = ALU_OR;
        ctl_o.mar_ld = 1'b1;
        nxt = (st == ST_MAR0) ? ST_RD0 : ST_RD1;
      end
      ST_RD0, ST_RD1: begin
        ctl_o.rd       = 1'b1;
        ctl_o.ir_lo_ld = (st == ST_RD0);
        ctl_o.ir_hi_ld = (st == ST_RD1);
        if (OVERLAP != 0) begin
          if (!mem_wait_i) begin
            ctl_o = add_inc(ctl_o);
            nxt   = (st == ST_RD0) ? ST_MAR1 : ST_DONE;
          end
        end else begin
          nxt = (st == ST_RD0) ? ST_CHK0 : ST_CHK1;
        end
      end
      ST_CHK0: nxt = stall_q ? ST_RD0 : ST_INC0;
      ST_CHK1: nxt = stall_q ? ST_RD1 : ST_INC1;
      ST_INC0, ST_INC1: begin
        ctl_o = add_inc(ctl_o);
        nxt   = (st == ST_INC0) ? ST_MAR1 : ST_DONE;
      end
      ST_DONE: begin
        done_o = 1'b1;
        nxt    = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st <= ST_IDLE;
    else         st <= nxt;
  end
endmodule

// File: rtl/fetch_alu.sv
module fetch_alu
  import fetch_seq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o
);
  logic [W-1:0] cin_ext;
  assign cin_ext = {{(W-1){1'b0}}, cin_i};

  always_comb begin
    unique case (op_i)
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_NOT:  y_o = ~a_i;
      ALU_ADD:  y_o = a_i + b_i + cin_ext;
      ALU_SUB:  y_o = a_i + ~b_i + cin_ext;
      ALU_ADDA: y_o = a_i + cin_ext;
      ALU_SUBA: y_o = a_i + {W{1'b1}} + cin_ext;
      default:  y_o = '0;
    endcase
  end
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs #(
  parameter int           W      = 8,
  parameter logic [W-1:0] PC_RST = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   res_i,
  input  logic [W-1:0]   rdata_i,
  input  logic           wait_i,
  input  logic           rd_i,
  input  logic           mar_ld_i,
  input  logic           pc_we_i,
  input  logic [1:0]     ir_ld_i,
  output logic [W-1:0]   pc_o,
  output logic [W-1:0]   mar_o,
  output logic [2*W-1:0] ir_o
);
  localparam int HALVES = 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o  <= PC_RST;
      mar_o <= '0;
    end else begin
      if (pc_we_i)  pc_o  <= res_i;
      if (mar_ld_i) mar_o <= res_i;
    end
  end

  // a half captures only on the cycle memory delivers
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ir_o[h*W +: W] <= '0;
      else if (rd_i && !wait_i && ir_ld_i[h]) ir_o[h*W +: W] <= rdata_i;
    end
  end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_seq_pkg::*;
#(
  parameter int           W       = 8,
  parameter int           OVERLAP = 1,
  parameter logic [W-1:0] PC_RST  = '0
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mem_wait_i,
  input  logic [W-1:0]   mem_rdata_i,
  output logic [W-1:0]   mem_addr_o,
  output logic [2:0]     a_sel_o,
  output logic [2:0]     b_sel_o,
  output logic [2:0]     alu_sel_o,
  output logic           cin_o,
  output logic [1:0]     res_sel_o,
  output logic           mar_ld_o,
  output logic           rd_o,
  output logic           ir_lo_ld_o,
  output logic           ir_hi_ld_o,
  output logic           pc_we_o,
  output logic           done_o,
  output logic [W-1:0]   pc_o,
  output logic [2*W-1:0] ir_o
);
  localparam logic [SEL_W-1:0] PC_REG = SEL_W'(7);

  ctl_t       ctl;
  logic [W-1:0] a_op, b_op, alu_y, pc_q;

  fetch_ctrl #(.OVERLAP(OVERLAP), .PC_REG(PC_REG)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_wait_i (mem_wait_i),
    .ctl_o      (ctl),
    .done_o     (done_o)
  );

  // only register 7 lives in this slice; other selects read as zero
  assign a_op = (ctl.a_sel == PC_REG) ? pc_q : '0;
  assign b_op = (ctl.b_sel == PC_REG) ? pc_q : '0;

  fetch_alu #(.W(W)) u_alu (
    .a_i   (a_op),
    .b_i   (b_op),
    .cin_i (ctl.cin),
    .op_i  (ctl.alu),
    .y_o   (alu_y)
  );

  fetch_regs #(.W(W), .PC_RST(PC_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .res_i    (alu_y),
    .rdata_i  (mem_rdata_i),
    .wait_i   (mem_wait_i),
    .rd_i     (ctl.rd),
    .mar_ld_i (ctl.mar_ld),
    .pc_we_i  (ctl.pc_we),
    .ir_ld_i  ({ctl.ir_hi_ld, ctl.ir_lo_ld}),
    .pc_o     (pc_q),
    .mar_o    (mem_addr_o),
    .ir_o     (ir_o)
  );

  assign pc_o       = pc_q;
  assign a_sel_o    = ctl.a_sel;
  assign b_sel_o    = ctl.b_sel;
  assign alu_sel_o  = ctl.alu;
  assign cin_o      = ctl.cin;
  assign res_sel_o  = ctl.res_sel;
  assign mar_ld_o   = ctl.mar_ld;
  assign rd_o       = ctl.rd;
  assign ir_lo_ld_o = ctl.ir_lo_ld;
  assign ir_hi_ld_o = ctl.ir_hi_ld;
  assign pc_we_o    = ctl.pc_we;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int W       = 8,
  parameter int OVERLAP = 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mem_wait_i,
  input logic [2:0]   a_sel_o,
  input logic [2:0]   b_sel_o,
  input logic [2:0]   alu_sel_o,
  input logic         cin_o,
  input logic [1:0]   res_sel_o,
  input logic         mar_ld_o,
  input logic         rd_o,
  input logic         ir_lo_ld_o,
  input logic         ir_hi_ld_o,
  input logic         pc_we_o,
  input logic         done_o,
  input logic [W-1:0] pc_o
);
  assert_mar_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mar_ld_o |-> (a_sel_o == 3'd7 && b_sel_o == 3'd7 && alu_sel_o == 3'd1));

  assert_inc_word_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (a_sel_o == 3'd7 && cin_o && alu_sel_o == 3'd6 && res_sel_o == 2'd0));

  assert_half_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ir_lo_ld_o, ir_hi_ld_o}) && ((ir_lo_ld_o || ir_hi_ld_o) == rd_o));

  assert_pc_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |=> pc_o == $past(pc_o) + W'(1));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !rd_o && !mar_ld_o && !pc_we_o);

  assert_no_mar_inc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_we_o && mar_ld_o));

  assert_no_inc_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && mem_wait_i) |-> !pc_we_o);

  if (OVERLAP != 0) begin : g_ovl
    assert_merge_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_o && !mem_wait_i) |-> pc_we_o);
  end else begin : g_seq
    assert_split_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_o |-> !pc_we_o);
  end
endmodule

bind fetch_seq fetch_seq_chk #(.W(W), .OVERLAP(OVERLAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_wait_i (mem_wait_i),
  .a_sel_o    (a_sel_o),
  .b_sel_o    (b_sel_o),
  .alu_sel_o  (alu_sel_o),
  .cin_o      (cin_o),
  .res_sel_o  (res_sel_o),
  .mar_ld_o   (mar_ld_o),
  .rd_o       (rd_o),
  .ir_lo_ld_o (ir_lo_ld_o),
  .ir_hi_ld_o (ir_hi_ld_o),
  .pc_we_o    (pc_we_o),
  .done_o     (done_o),
  .pc_o       (pc_o)
);

// File: tb/sim_fetch_seq.sv
module sim_fetch_seq;
  localparam int           W   = 8;
  localparam logic [W-1:0] PC0 = 8'hFC;

  typedef struct {
    logic [W-1:0]   pc0;
    logic [2*W-1:0] ir;
    int             lat0;
    int             lat1;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int   k_cur = 0;
  int   total = 0;
  int   bad = 0;

  always #4 clk = ~clk;

  function automatic logic [W-1:0] mem_f(input logic [W-1:0] a);
    return W'((a * 37 + 11)) ^ 8'h5A;
  endfunction

  logic [W-1:0]   addr_w [2];
  logic [W-1:0]   rdata_w[2];
  logic           wait_w [2];
  logic [2:0]     a_w    [2];
  logic [2:0]     b_w    [2];
  logic [2:0]     alu_w  [2];
  logic           cin_w  [2];
  logic [1:0]     res_w  [2];
  logic           mar_w  [2];
  logic           rd_w   [2];
  logic           lo_w   [2];
  logic           hi_w   [2];
  logic           we_w   [2];
  logic           done_w [2];
  logic [W-1:0]   pc_w   [2];
  logic [2*W-1:0] ir_w   [2];

  for (genvar g = 0; g < 2; g++) begin : lane
    int cnt;
    fetch_seq #(.W(W), .OVERLAP(g), .PC_RST(PC0)) u0 (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .start_i     (start),
      .mem_wait_i  (wait_w[g]),
      .mem_rdata_i (rdata_w[g]),
      .mem_addr_o  (addr_w[g]),
      .a_sel_o     (a_w[g]),
      .b_sel_o     (b_w[g]),
      .alu_sel_o   (alu_w[g]),
      .cin_o       (cin_w[g]),
      .res_sel_o   (res_w[g]),
      .mar_ld_o    (mar_w[g]),
      .rd_o        (rd_w[g]),
      .ir_lo_ld_o  (lo_w[g]),
      .ir_hi_ld_o  (hi_w[g]),
      .pc_we_o     (we_w[g]),
      .done_o      (done_w[g]),
      .pc_o        (pc_w[g]),
      .ir_o        (ir_w[g])
    );
    // memory stalls k_cur read cycles after each address load
    always @(posedge clk) begin
      if (mar_w[g])                cnt <= k_cur;
      else if (rd_w[g] && cnt > 0) cnt <= cnt - 1;
    end
    assign wait_w[g]  = rd_w[g] && (cnt != 0);
    assign rdata_w[g] = wait_w[g] ? 8'hEE : mem_f(addr_w[g]);
  end

  item_t exp_q[$];
  bit    busy[2];
  int    cyc[2];
  int    nb[2];
  bit    post[2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] ctl_bits(input int g);
    return {a_w[g], b_w[g], alu_w[g], cin_w[g], res_w[g], mar_w[g], rd_w[g],
            lo_w[g], hi_w[g], we_w[g], done_w[g]};
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < 2; g++) begin
        if (post[g]) begin
          chk(!done_w[g], "R6 single done", 32'(done_w[g]), 0);
          post[g] = 1'b0;
        end
        if (busy[g]) begin
          cyc[g]++;
          if (exp_q.size() == 0) begin
            chk(1'b0, "R4 queue empty", 0, 1);
            busy[g] = 1'b0;
          end else begin
            if (mar_w[g]) chk(a_w[g] == 3'd7 && b_w[g] == 3'd7 && alu_w[g] == 3'd1,
                              "R8 mar word", {a_w[g], b_w[g], alu_w[g]}, {3'd7, 3'd7, 3'd1});
            if (we_w[g]) chk(a_w[g] == 3'd7 && cin_w[g] && alu_w[g] == 3'd6 && res_w[g] == 0,
                             "R8 inc word", {a_w[g], cin_w[g], alu_w[g]}, {3'd7, 1'b1, 3'd6});
            if (we_w[g]) chk(!mar_w[g] && !(rd_w[g] && wait_w[g]), "R10 inc clash",
                             {mar_w[g], wait_w[g]}, 0);
            if (rd_w[g] && !wait_w[g]) begin
              chk(addr_w[g] == W'(exp_q[0].pc0 + nb[g]), "R3 byte address",
                  addr_w[g], W'(exp_q[0].pc0 + nb[g]));
              if (g == 1) chk(we_w[g], "R9 merged inc", we_w[g], 1);
              nb[g]++;
            end
            if (g == 0 && rd_w[g]) chk(!we_w[g], "R9 split inc", we_w[g], 0);
            if (done_w[g]) begin
              chk(cyc[g] == (g == 0 ? exp_q[0].lat0 : exp_q[0].lat1), "R7 latency",
                  cyc[g], g == 0 ? exp_q[0].lat0 : exp_q[0].lat1);
              chk(ir_w[g] == exp_q[0].ir, "R4 instruction", ir_w[g], exp_q[0].ir);
              chk(pc_w[g] == W'(exp_q[0].pc0 + 2), "R5 pc plus two", pc_w[g],
                  W'(exp_q[0].pc0 + 2));
              chk(nb[g] == 2, "R3 byte count", nb[g], 2);
              busy[g] = 1'b0;
              post[g] = 1'b1;
              if (g == 0) void'(exp_q.pop_front());
            end
          end
        end else begin
          chk(ctl_bits(g) == '0, "R2 idle quiet", ctl_bits(g), 0);
          if (start) begin
            busy[g] = 1'b1;
            cyc[g]  = 0;
            nb[g]   = 0;
          end
        end
      end
    end
  end

  logic [W-1:0] pc_m = PC0;

  task automatic fetch(input int k, input bit extra);
    item_t it;
    k_cur   = k;
    it.pc0  = pc_m;
    it.ir   = {mem_f(W'(pc_m + 1)), mem_f(pc_m)};
    it.lat0 = 9 + 4 * k;
    it.lat1 = 5 + 2 * k;
    exp_q.push_back(it);
    pc_m = W'(pc_m + 2);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    if (extra) begin
      // R6: a start pulse mid-fetch must be ignored
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    for (int i = 0; i < 200 && (busy[0] || busy[1]); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk(ctl_bits(g) == '0, "R1 reset controls", ctl_bits(g), 0);
      chk(pc_w[g] == PC0, "R1 reset pc", pc_w[g], PC0);
      chk(ir_w[g] == '0, "R1 reset ir", ir_w[g], 0);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fetch(0, 1'b0);
    fetch(0, 1'b0);   // R5: counter wraps past the top
    fetch(2, 1'b0);
    fetch(0, 1'b1);
    fetch(1, 1'b0);
    fetch(3, 1'b0);
    repeat (10) @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      chk(pc_w[g] == pc_m, "R6 pc after ignored start", pc_w[g], pc_m);
      chk(!busy[g], "R2 settled idle", busy[g], 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule